// File: doc/BRIEF.md
# Packed 8-bit dot-product accumulator

This execution unit splits two source vectors into 32-bit lanes and treats every lane as four packed 8-bit elements. In each active lane it multiplies the elements pairwise, adds the four products, and adds that sum to the same lane of an accumulator vector. The updated vector is returned. One select bit chooses two's-complement or unsigned elements. A second select bit chooses a 64-bit operation (the two low lanes) or a 128-bit operation (all four lanes).

The unit also receives the three 5-bit register indices of the operation: destination, first source and second source. Each index is the extension bit placed above a 4-bit field. In the 128-bit mode every index must be even. An odd index raises an undefined-operation flag, and the accumulator is returned untouched. The unit has one register stage, with a valid/ready handshake on each side.

Top module: `dotacc_unit`

## Requirements
- R1: For every active lane k, `acc_out[32k+31:32k]` equals `acc_in[32k+31:32k]` plus the sum over i=0..3 of a_i*b_i. Element i of lane k occupies bits `[32k+8i+7 : 32k+8i]` of `src_a` and `src_b`.
- R2: When `unsigned_sel`=0, elements are two's-complement values (-128..127). The four-product sum is sign-extended before it is added.
- R3: When `unsigned_sel`=1, elements are unsigned values (0..255). The four-product sum is zero-extended before it is added.
- R4: When `wide_sel`=0, only lanes 0 and 1 are computed. Bits 127:64 of `acc_out` equal bits 127:64 of `acc_in`.
- R5: When `wide_sel`=1, all four lanes are computed.
- R6: When `wide_sel`=1 and bit 0 of `dst_idx`, `srca_idx` or `srcb_idx` is 1, the result carries `undef_op`=1 and `acc_out` equals `acc_in` in full.
- R7: When `wide_sel`=0, odd indices are legal and the result carries `undef_op`=0.
- R8: The lane addition wraps modulo 2^32. There is no saturation.
- R9: An input accepted on a clock edge (`in_valid` and `in_ready` both high) appears at the outputs with `out_valid`=1 after that same edge. `out_valid` is low while no result is pending.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `acc_out` and `undef_op` hold their values.
- R11: During reset and right after it, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| acc_in | input | 128 | Accumulator vector |
| unsigned_sel | input | 1 | 1 = unsigned elements, 0 = signed elements |
| wide_sel | input | 1 | 1 = 128-bit operation, 0 = 64-bit operation |
| dst_idx | input | 5 | Destination register index |
| srca_idx | input | 5 | First source register index |
| srcb_idx | input | 5 | Second source register index |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Result taken |
| acc_out | output | 128 | Updated accumulator vector |
| undef_op | output | 1 | Operation was illegal; accumulator not changed |

## Verification
The bench builds the unit with its default parameters: 8-bit elements, four elements per lane, four lanes, two lanes in the narrow mode and 5-bit indices. These values give both width modes and the full sign and range of the products. The extreme operands are reachable: all-0x80 gives a signed sum of +65536, and all-0xFF gives an unsigned sum of 260100, which are the largest magnitudes the 18-bit sum must carry. The odd-index rule can be exercised on each of the three indices in turn, and the accumulator can be driven up to the 32-bit wrap point.

// File: rtl/dotacc_pkg.sv
// Package dotacc_pkg
// Shared sizing defaults and a width helper for the packed dot-product
// accumulator. Assumes element widths of at least 2 bits.
package dotacc_pkg;
    localparam int DEF_ELEM_W       = 8;
    localparam int DEF_ELEMS        = 4;
    localparam int DEF_LANES        = 4;
    localparam int DEF_NARROW_LANES = 2;
    localparam int DEF_IDX_W        = 5;

    // Width of a sum of `terms` values that are each `w` bits wide.
    function automatic int sum_width(input int w, input int terms);
        return w + $clog2(terms);
    endfunction
endpackage

// File: rtl/dotacc_lane.sv
// Module dotacc_lane
// One lane: ELEMS pairwise products of ELEM_W-bit elements, reduced and
// added to the lane's accumulator value. `uns` picks zero or sign extension.
// When `en` is low the accumulator passes through. Purely combinational.
module dotacc_lane #(
    parameter int ELEM_W = dotacc_pkg::DEF_ELEM_W,
    parameter int ELEMS  = dotacc_pkg::DEF_ELEMS
) (
    input  logic [ELEM_W*ELEMS-1:0] a_lane,
    input  logic [ELEM_W*ELEMS-1:0] b_lane,
    input  logic [ELEM_W*ELEMS-1:0] acc_lane,
    input  logic                    uns,
    input  logic                    en,
    output logic [ELEM_W*ELEMS-1:0] res_lane
);
    localparam int LANE_W = ELEM_W * ELEMS;
    localparam int PROD_W = 2 * ELEM_W;
    localparam int SUM_W  = dotacc_pkg::sum_width(PROD_W, ELEMS);

    logic [PROD_W-1:0] prod [ELEMS];
    logic [SUM_W-1:0]  sum;
    logic [LANE_W-1:0] sum_x;

    for (genvar i = 0; i < ELEMS; i++) begin : g_mul
        logic signed [ELEM_W:0]   ea, eb;
        logic signed [PROD_W-1:0] p;
        // Widen each element by one bit so a single signed multiply covers both modes.
        always_comb begin
            ea = {(~uns & a_lane[ELEM_W*i+ELEM_W-1]), a_lane[ELEM_W*i +: ELEM_W]};
            eb = {(~uns & b_lane[ELEM_W*i+ELEM_W-1]), b_lane[ELEM_W*i +: ELEM_W]};
            p  = ea * eb;
        end
        assign prod[i] = p;
    end

    // Reduce the products, extending each one according to the mode.
    always_comb begin
        sum = '0;
        for (int i = 0; i < ELEMS; i++) begin
            if (uns)
                sum = sum + {{(SUM_W-PROD_W){1'b0}}, prod[i]};
            else
                sum = sum + {{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
        end
    end

    // Extend the reduced sum to the lane width, then add it modulo 2^LANE_W.
    always_comb begin
        sum_x    = {{(LANE_W-SUM_W){~uns & sum[SUM_W-1]}}, sum};
        res_lane = en ? (acc_lane + sum_x) : acc_lane;
    end
endmodule

// File: rtl/dotacc_legal.sv
// Module dotacc_legal
// Flags an illegal operation: in the wide mode, every register index must
// have bit 0 clear. Assumes the indices are packed side by side in `idx`.
module dotacc_legal #(
    parameter int IDX_W   = dotacc_pkg::DEF_IDX_W,
    parameter int NUM_IDX = 3
) (
    input  logic                     wide,
    input  logic [IDX_W*NUM_IDX-1:0] idx,
    output logic                     illegal
);
    logic [NUM_IDX-1:0] odd;

    for (genvar j = 0; j < NUM_IDX; j++) begin : g_odd
        assign odd[j] = idx[IDX_W*j];
    end

    // An operation is illegal only in the wide mode.
    always_comb illegal = wide & (|odd);
endmodule

// File: rtl/dotacc_stage.sv
// Module dotacc_stage
// One register stage with a valid/ready handshake. It takes new data when
// empty or when the held word leaves in the same cycle. Synchronous active-low reset.
module dotacc_stage #(
    parameter int W = 129
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    // The stage can accept when it is empty or being drained.
    always_comb in_ready = ~out_valid | out_ready;

    // Load, hold or empty the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dotacc_unit.sv
// Module dotacc_unit
// Packed dot-product accumulator. Each lane of LANE_W bits holds ELEMS
// elements. In the narrow mode the low NARROW_LANES lanes are computed and
// the rest pass through. In the wide mode all lanes are computed. An illegal
// wide operation returns the accumulator unchanged with undef_op set.
// The result is registered once.
module dotacc_unit #(
    parameter int ELEM_W       = dotacc_pkg::DEF_ELEM_W,
    parameter int ELEMS        = dotacc_pkg::DEF_ELEMS,
    parameter int LANES        = dotacc_pkg::DEF_LANES,
    parameter int NARROW_LANES = dotacc_pkg::DEF_NARROW_LANES,
    parameter int IDX_W        = dotacc_pkg::DEF_IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [ELEM_W*ELEMS*LANES-1:0] src_a,
    input  logic [ELEM_W*ELEMS*LANES-1:0] src_b,
    input  logic [ELEM_W*ELEMS*LANES-1:0] acc_in,
    input  logic                          unsigned_sel,
    input  logic                          wide_sel,
    input  logic [IDX_W-1:0]              dst_idx,
    input  logic [IDX_W-1:0]              srca_idx,
    input  logic [IDX_W-1:0]              srcb_idx,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [ELEM_W*ELEMS*LANES-1:0] acc_out,
    output logic                          undef_op
);
    localparam int LANE_W = ELEM_W * ELEMS;
    localparam int VEC_W  = LANE_W * LANES;

    logic             illegal;
    logic [LANES-1:0] lane_en;
    logic [VEC_W-1:0] lane_res;

    dotacc_legal #(.IDX_W(IDX_W), .NUM_IDX(3)) u_legal (
        .wide    (wide_sel),
        .idx     ({srcb_idx, srca_idx, dst_idx}),
        .illegal (illegal)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // A lane is active when the mode covers it and the operation is legal.
        if (k < NARROW_LANES) begin : g_low
            assign lane_en[k] = ~illegal;
        end else begin : g_high
            assign lane_en[k] = wide_sel & ~illegal;
        end

        dotacc_lane #(.ELEM_W(ELEM_W), .ELEMS(ELEMS)) u_lane (
            .a_lane   (src_a[LANE_W*k +: LANE_W]),
            .b_lane   (src_b[LANE_W*k +: LANE_W]),
            .acc_lane (acc_in[LANE_W*k +: LANE_W]),
            .uns      (unsigned_sel),
            .en       (lane_en[k]),
            .res_lane (lane_res[LANE_W*k +: LANE_W])
        );
    end

    dotacc_stage #(.W(VEC_W + 1)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   ({illegal, lane_res}),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  ({undef_op, acc_out})
    );
endmodule

// File: rtl/dotacc_unit_chk.sv
// Module dotacc_unit_chk
// Temporal checks on the ports of dotacc_unit, attached by bind.
module dotacc_unit_chk #(
    parameter int VEC_W  = 128,
    parameter int HALF_W = 64,
    parameter int IDX_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [VEC_W-1:0] acc_in,
    input logic             wide_sel,
    input logic [IDX_W-1:0] dst_idx,
    input logic [IDX_W-1:0] srca_idx,
    input logic [IDX_W-1:0] srcb_idx,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] acc_out,
    input logic             undef_op
);
    // R9
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R10
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R10
    stall_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(acc_out) && $stable(undef_op)));

    // R6
    odd_index_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && wide_sel && (dst_idx[0] || srca_idx[0] || srcb_idx[0]))
        |=> (undef_op && acc_out == $past(acc_in)));

    // R4
    narrow_upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !wide_sel)
        |=> (acc_out[VEC_W-1:HALF_W] == $past(acc_in[VEC_W-1:HALF_W])));

    // R7
    narrow_always_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !wide_sel) |=> !undef_op);
endmodule

bind dotacc_unit dotacc_unit_chk #(
    .VEC_W  (ELEM_W*ELEMS*LANES),
    .HALF_W (ELEM_W*ELEMS*NARROW_LANES),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .acc_in    (acc_in),
    .wide_sel  (wide_sel),
    .dst_idx   (dst_idx),
    .srca_idx  (srca_idx),
    .srcb_idx  (srcb_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .acc_out   (acc_out),
    .undef_op  (undef_op)
);

// File: tb/dotacc_unit_bench.sv
// Bench for dotacc_unit: an integer reference model fed through a queue,
// compared with the outputs on every falling clock edge.
module dotacc_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, out_ready = 1'b1;
    logic         in_ready, out_valid, undef_op;
    logic [127:0] src_a = '0, src_b = '0, acc_in = '0, acc_out;
    logic         unsigned_sel = 1'b0, wide_sel = 1'b0;
    logic [4:0]   dst_idx = '0, srca_idx = '0, srcb_idx = '0;

    // staged inputs for the next cycle
    logic         s_v, s_u, s_w, s_r;
    logic [127:0] s_a, s_b, s_acc;
    logic [4:0]   s_d, s_n, s_m;

    typedef struct { logic [127:0] d; logic u; string tag; } exp_t;
    exp_t q[$];
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    dotacc_unit u_dotacc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .unsigned_sel(unsigned_sel), .wide_sel(wide_sel),
        .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
        .out_valid(out_valid), .out_ready(out_ready),
        .acc_out(acc_out), .undef_op(undef_op)
    );

    function automatic void model(input logic [127:0] a, b, acc, input logic u, w,
                                  input logic [4:0] di, ni, mi,
                                  output logic [127:0] r, output logic ud);
        ud = w && (di[0] || ni[0] || mi[0]);
        r  = acc;
        if (!ud) begin
            for (int k = 0; k < (w ? 4 : 2); k++) begin
                int s = 0;
                for (int i = 0; i < 4; i++) begin
                    int x, y;
                    x = u ? int'(a[32*k+8*i +: 8]) : int'($signed(a[32*k+8*i +: 8]));
                    y = u ? int'(b[32*k+8*i +: 8]) : int'($signed(b[32*k+8*i +: 8]));
                    s += x * y;
                end
                r[32*k +: 32] = acc[32*k +: 32] + 32'(s);
            end
        end
    endfunction

    task automatic step(input string tag);
        exp_t e;
        @(negedge clk);
        n_chk++;
        if (out_valid !== (q.size() != 0)) begin
            n_bad++;
            $display("FAIL R9 out_valid actual=%b expected=%b", out_valid, q.size() != 0);
        end
        if (out_valid && q.size() != 0) begin
            n_chk++;
            if (acc_out !== q[0].d || undef_op !== q[0].u) begin
                n_bad++;
                $display("FAIL %s actual=%h/%b expected=%h/%b", q[0].tag, acc_out, undef_op,
                         q[0].d, q[0].u);
            end
        end
        in_valid = s_v; src_a = s_a; src_b = s_b; acc_in = s_acc;
        unsigned_sel = s_u; wide_sel = s_w; dst_idx = s_d; srca_idx = s_n; srcb_idx = s_m;
        out_ready = s_r;
        #1;
        if (out_valid && !out_ready) begin
            n_chk++;
            if (in_ready !== 1'b0) begin
                n_bad++;
                $display("FAIL R10 in_ready actual=%b expected=0", in_ready);
            end
        end
        if (out_valid && out_ready) void'(q.pop_front());
        if (in_valid && in_ready) begin
            model(src_a, src_b, acc_in, unsigned_sel, wide_sel, dst_idx, srca_idx, srcb_idx,
                  e.d, e.u);
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic send(input logic [127:0] a, b, acc, input logic u, w,
                        input logic [4:0] di, ni, mi, input string tag);
        s_v = 1'b1; s_a = a; s_b = b; s_acc = acc; s_u = u; s_w = w;
        s_d = di; s_n = ni; s_m = mi; s_r = 1'b1;
        step(tag);
    endtask

    task automatic idle(input int n);
        s_v = 1'b0; s_r = 1'b1;
        for (int i = 0; i < n; i++) step("R9");
    endtask

    initial begin
        s_v = 0; s_u = 0; s_w = 0; s_r = 1; s_a = '0; s_b = '0; s_acc = '0;
        s_d = '0; s_n = '0; s_m = '0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R11 in reset valid/ready actual=%b/%b expected=0/1", out_valid, in_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R11 after reset valid/ready actual=%b/%b expected=0/1", out_valid, in_ready);
        end

        // small signed values, narrow mode, upper lanes must pass through
        send({32'hDEAD_BEEF, 32'h1234_5678, 32'h01FF_02FE, 32'h0304_FB06},
             {32'h1111_1111, 32'h2222_2222, 32'h0302_0101, 32'h7F80_0102},
             {32'hAAAA_5555, 32'h0F0F_F0F0, 32'h0000_0010, 32'hFFFF_FFF0}, 0, 0, 0, 0, 0, "R1 R2 R4");
        // same operands, unsigned
        send({32'hDEAD_BEEF, 32'h1234_5678, 32'h01FF_02FE, 32'h0304_FB06},
             {32'h1111_1111, 32'h2222_2222, 32'h0302_0101, 32'h7F80_0102},
             '0, 1, 0, 0, 0, 0, "R3");
        // all 0x80 signed, wide
        send({16{8'h80}}, {16{8'h80}}, '0, 0, 1, 0, 2, 4, "R2 R5 all-0x80");
        // all 0xFF unsigned and signed, wide
        send({16{8'hFF}}, {16{8'hFF}}, {4{32'h0000_0100}}, 1, 1, 4, 6, 8, "R3 R5 all-0xFF");
        send({16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFF_FFFE}}, 0, 1, 0, 0, 0, "R2 R8 all-0xFF");
        // wrap past 2^32
        send({16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFF_0000}}, 1, 1, 2, 2, 2, "R8 wrap");
        send({16{8'h80}}, {16{8'h7F}}, {4{32'h0000_1000}}, 0, 1, 2, 2, 2, "R8 negative");
        // odd index in each position, wide mode
        send({16{8'h11}}, {16{8'h22}}, {4{32'hCAFE_F00D}}, 0, 1, 1, 0, 0, "R6 dst odd");
        send({16{8'h11}}, {16{8'h22}}, {4{32'h1357_9BDF}}, 1, 1, 0, 3, 0, "R6 srca odd");
        send({16{8'h11}}, {16{8'h22}}, {4{32'h0246_8ACE}}, 0, 1, 16, 16, 31, "R6 srcb odd");
        // odd indices in narrow mode are legal
        send({16{8'h05}}, {16{8'hFD}}, {4{32'h0000_0007}}, 0, 0, 1, 3, 17, "R7");
        idle(2);

        // random traffic with random back-pressure
        for (int t = 0; t < 400; t++) begin
            s_v = ($urandom_range(0, 3) != 0);
            s_a = {$urandom, $urandom, $urandom, $urandom};
            s_b = {$urandom, $urandom, $urandom, $urandom};
            s_acc = {$urandom, $urandom, $urandom, $urandom};
            s_u = $urandom_range(0, 1); s_w = $urandom_range(0, 1);
            s_d = 5'($urandom); s_n = 5'($urandom & 5'h1E | (($urandom_range(0, 7) == 0) ? 1 : 0));
            s_m = 5'($urandom & 5'h1E);
            s_r = ($urandom_range(0, 2) != 0);
            step("R1 R10 random");
        end
        idle(3);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule